// File: doc/BRIEF.md
# Parallel RGB display output formatter

This block sits between a video timing generator and the pins of a parallel RGB panel. It runs in the pixel clock domain. Each cycle it takes a 24-bit pixel (red in bits 23:16, green in 15:8, blue in 7:0) together with horizontal sync, vertical sync and data-enable. It can swap the three colour channels and then pack them onto a 24-line bus in one of several zero-padded layouts. Each sync output has its own controls for inversion, launch on the falling clock edge, and forcing low. The pixel clock leaving the block can also be inverted.

Software programs a single control word through a simple write strobe, address and data bus. A read at any offset other than zero returns a fixed identifier. A new control value only reaches the output path at the start of the next frame, which is the first cycle the incoming vertical sync is seen high after being low. The exception is while the block is disabled: then a new control value takes effect on the next clock.

Top module: `rgb_pin_formatter`

## Requirements
- R1: A read at offset 0 returns the control word, which resets to 0. A read at any non-zero offset returns 32'h00647069.
- R2: Control bits 15:14 choose the channel order used as the packer's first, second and third channel: 0 keeps R,G,B; 1 gives B,G,R; 2 gives G,R,B; 3 gives B,R,G.
- R3: Control bits 13:11 choose the packing. The channels below are the reordered first/second/third channels (c0/c1/c2), and each is shortened by dropping its low bits.
  - 1: {8'b0, c0[7:3], c1[7:2], c2[7:3]}
  - 2: c0[7:3] on lines 20:16, c1[7:2] on 13:8, c2[7:3] on 4:0
  - 3: c0[7:3] on 21:17, c1[7:2] on 13:8, c2[7:3] on 5:1
  - 4: {6'b0, c0[7:2], c1[7:2], c2[7:2]}
  - 5: each channel's [7:2] in the low six bits of its own byte
  - 6: {c0, c1, c2}
  - 0 and 7: all zeros
- R4: Data, hsync, vsync and the enable pin pass through exactly one register stage clocked on the rising edge, so they stay aligned with each other.
- R5: Control bits 10, 9, 8 and 7 invert the pixel clock output, hsync, vsync and the enable pin respectively.
- R6: Control bits 6, 5 and 4 make hsync, vsync and the enable pin launch on the falling clock edge, half a cycle after the registered value.
- R7: Control bits 3, 2 and 1 force hsync, vsync and the enable pin to 0, whatever the inversion setting.
- R8: Control bit 0 enables the block. While the active value is 0, data, sync, enable and pixel clock outputs are 0 and the pipeline is held cleared, so the first cycle after enabling shows zeros.
- R9: With control bit 16 set, the enable pin carries data-enable. With it clear, the pin carries a composite sync (hsync OR vsync), with polarity set by bit 7.
- R10: While enabled, a control write changes the read-back value at once but the output path only after an incoming vsync rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_addr | input | AW | Byte offset for read and write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data (combinational on cfg_addr) |
| pix_rgb | input | 24 | Incoming pixel, R in 23:16, G in 15:8, B in 7:0 |
| pix_hs | input | 1 | Incoming horizontal sync, active high |
| pix_vs | input | 1 | Incoming vertical sync, active high |
| pix_de | input | 1 | Incoming data-enable |
| out_data | output | 24 | Packed pixel lines |
| out_hs | output | 1 | Conditioned horizontal sync |
| out_vs | output | 1 | Conditioned vertical sync |
| out_en | output | 1 | Data-enable or composite sync pin |
| out_pclk | output | 1 | Pixel clock to the panel |

## Verification
The bench runs one pixel through every packing code, including the two codes that must output zeros, and through all four channel orders. A packer with a bit range off by one, or an order table with two entries swapped, would give a wrong word on the bus. The bench times the falling-edge launch against the half-cycle point and checks that a disabled sync stays low even when inverted. A design that let disable be overridden by inversion would drive the pin high. Other checks hold a control write back until vsync and confirm that re-enabling starts from a cleared pipeline; a design that applied the control word at once, or kept stale pixels across the disable, would show the wrong data. Composite-sync mode is checked in both polarities.

// File: rtl/rgb_pin_formatter.sv
module rgb_pin_formatter #(
  parameter int          AW      = 8,
  parameter logic [31:0] ID_WORD = 32'h0064_7069
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [23:0]   pix_rgb,
  input  logic          pix_hs,
  input  logic          pix_vs,
  input  logic          pix_de,
  output logic [23:0]   out_data,
  output logic          out_hs,
  output logic          out_vs,
  output logic          out_en,
  output logic          out_pclk
);
  localparam int CW = 8;

  logic [31:0] ctrl;
  logic [16:0] act;
  logic        vs_prev;
  logic        vs_rise;

  assign vs_rise   = pix_vs & ~vs_prev;
  assign cfg_rdata = (cfg_addr == '0) ? ctrl : ID_WORD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      act     <= '0;
      vs_prev <= 1'b0;
    end else begin
      if (cfg_wr && cfg_addr == '0) ctrl <= cfg_wdata;
      vs_prev <= pix_vs;
      if (!act[0] || vs_rise) act <= ctrl[16:0];
    end
  end

  logic [CW-1:0] r, g, b, c0, c1, c2;
  logic [23:0]   packed_px;

  assign {r, g, b} = pix_rgb;

  always_comb begin
    unique case (act[15:14])
      2'd0:    {c0, c1, c2} = {r, g, b};
      2'd1:    {c0, c1, c2} = {b, g, r};
      2'd2:    {c0, c1, c2} = {g, r, b};
      default: {c0, c1, c2} = {b, r, g};
    endcase
  end

  always_comb begin
    unique case (act[13:11])
      3'd1:    packed_px = {8'b0, c0[7:3], c1[7:2], c2[7:3]};
      3'd2:    packed_px = {3'b0, c0[7:3], 2'b0, c1[7:2], 3'b0, c2[7:3]};
      3'd3:    packed_px = {2'b0, c0[7:3], 3'b0, c1[7:2], 2'b0, c2[7:3], 1'b0};
      3'd4:    packed_px = {6'b0, c0[7:2], c1[7:2], c2[7:2]};
      3'd5:    packed_px = {2'b0, c0[7:2], 2'b0, c1[7:2], 2'b0, c2[7:2]};
      3'd6:    packed_px = {c0, c1, c2};
      default: packed_px = '0;
    endcase
  end

  logic [23:0] data_q;
  logic        hs_q, vs_q, en_q;
  logic        hs_n, vs_n, en_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      en_q   <= 1'b0;
    end else if (!act[0]) begin
      data_q <= '0;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      data_q <= packed_px;
      hs_q   <= pix_hs;
      vs_q   <= pix_vs;
      en_q   <= act[16] ? pix_de : (pix_hs | pix_vs);
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_n <= 1'b0;
      vs_n <= 1'b0;
      en_n <= 1'b0;
    end else begin
      hs_n <= hs_q;
      vs_n <= vs_q;
      en_n <= en_q;
    end
  end

  logic on;
  assign on = act[0];

  assign out_data = on ? data_q : '0;
  assign out_hs   = on && !act[3] && ((act[6] ? hs_n : hs_q) ^ act[9]);
  assign out_vs   = on && !act[2] && ((act[5] ? vs_n : vs_q) ^ act[8]);
  assign out_en   = on && !act[1] && ((act[4] ? en_n : en_q) ^ act[7]);
  assign out_pclk = on && (clk ^ act[10]);
endmodule

// File: rtl/rgb_pin_formatter_chk.sv
module rgb_pin_formatter_chk #(
  parameter int          AW      = 8,
  parameter logic [31:0] ID_WORD = 32'h0064_7069
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cfg_addr,
  input logic [31:0]   cfg_rdata,
  input logic [23:0]   pix_rgb,
  input logic          pix_vs,
  input logic          vs_prev,
  input logic [16:0]   act,
  input logic [23:0]   out_data,
  input logic          out_hs,
  input logic          out_vs,
  input logic          out_en
);
  assert_id_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr != '0) |-> (cfg_rdata == ID_WORD));

  assert_pass_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act[0] && act[15:11] == 5'b00110 && $past(act) == act) |-> (out_data == $past(pix_rgb)));

  assert_hs_forced_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act[0] && act[3]) |-> !out_hs);

  assert_idle_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !act[0] |-> (out_data == '0 && !out_hs && !out_vs && !out_en));

  assert_frame_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (act[0] && !(pix_vs && !vs_prev)) |=> (act == $past(act)));
endmodule

bind rgb_pin_formatter rgb_pin_formatter_chk #(.AW(AW), .ID_WORD(ID_WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .pix_rgb(pix_rgb), .pix_vs(pix_vs), .vs_prev(vs_prev), .act(act),
  .out_data(out_data), .out_hs(out_hs), .out_vs(out_vs), .out_en(out_en)
);

// File: tb/rgb_pin_formatter_tb.sv
`timescale 1ns/1ps
module rgb_pin_formatter_tb;
  localparam int AW = 8;
  localparam logic [31:0] ID = 32'h0064_7069;
  localparam logic [23:0] PX = 24'hF1_8C35;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic [23:0]   pix_rgb = '0;
  logic          pix_hs = 1'b0, pix_vs = 1'b0, pix_de = 1'b0;
  logic [23:0]   out_data;
  logic          out_hs, out_vs, out_en, out_pclk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rgb_pin_formatter #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pix_rgb(pix_rgb),
    .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de), .out_data(out_data),
    .out_hs(out_hs), .out_vs(out_vs), .out_en(out_en), .out_pclk(out_pclk)
  );

  // {order[1:0], fmt[2:0], expected[23:0]} for pixel PX
  localparam logic [28:0] VEC [15] = '{
    {2'd0, 3'd6, 24'hF18C35}, {2'd0, 3'd1, 24'h00F466}, {2'd0, 3'd2, 24'h1E2306},
    {2'd0, 3'd3, 24'h3C230C}, {2'd0, 3'd4, 24'h03C8CD}, {2'd0, 3'd5, 24'h3C230D},
    {2'd0, 3'd0, 24'h000000}, {2'd0, 3'd7, 24'h000000}, {2'd1, 3'd6, 24'h358CF1},
    {2'd2, 3'd6, 24'h8CF135}, {2'd3, 3'd6, 24'h35F18C}, {2'd1, 3'd1, 24'h00347E},
    {2'd2, 3'd5, 24'h233C0D}, {2'd3, 3'd0, 24'h000000}, {2'd1, 3'd7, 24'h000000}
  };

  task automatic chk(string req, logic [31:0] act_v, logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  task automatic wr(logic [31:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = '0; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk); pix_vs = 1'b1;
    @(negedge clk); pix_vs = 1'b0;
  endtask

  function automatic logic [31:0] cfg(int ord, int fmt, logic [16:0] extra);
    return 32'(extra) | 32'h1 | (32'(ord) << 14) | (32'(fmt) << 11);
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    pix_rgb = PX; pix_hs = 1'b1; pix_de = 1'b1;
    #2;
    chk("R8 reset data", {8'b0, out_data}, 32'h0);
    chk("R8 reset syncs", {29'b0, out_hs, out_vs, out_en}, 32'h0);
    #20 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 ctrl reset", cfg_rdata, 32'h0);
    cfg_addr = 8'h04; #1 chk("R1 id at 4", cfg_rdata, ID);
    cfg_addr = 8'h10; #1 chk("R1 id at 0x10", cfg_rdata, ID);
    cfg_addr = '0;
    @(posedge clk); #2;
    chk("R8 pclk idle", {31'b0, out_pclk}, 32'h0);
    pix_hs = 1'b0; pix_de = 1'b0;

    // R2/R3 table
    for (int i = 0; i < 15; i++) begin
      wr(cfg(int'(VEC[i][28:27]), int'(VEC[i][26:24]), 17'h10000));
      frame();
      @(negedge clk); pix_rgb = PX;
      @(posedge clk); #2;
      chk($sformatf("R2/R3 order=%0d fmt=%0d", VEC[i][28:27], VEC[i][26:24]),
          {8'b0, out_data}, {8'b0, VEC[i][23:0]});
    end

    // R4 latency and alignment
    wr(cfg(0, 6, 17'h10000)); frame();
    @(negedge clk); pix_rgb = 24'h123456; pix_hs = 1'b0; pix_de = 1'b0;
    @(negedge clk); pix_rgb = 24'hABCDEF; pix_hs = 1'b1; pix_de = 1'b1;
    #2;
    chk("R4 before edge data", {8'b0, out_data}, 32'h123456);
    chk("R4 before edge hs/en", {30'b0, out_hs, out_en}, 32'h0);
    @(posedge clk); #2;
    chk("R4 after edge data", {8'b0, out_data}, 32'hABCDEF);
    chk("R4 after edge hs/en", {30'b0, out_hs, out_en}, 32'h3);
    chk("R5 pclk plain", {31'b0, out_pclk}, 32'h1);

    // R5 polarity
    @(negedge clk); pix_hs = 1'b0; pix_de = 1'b0;
    wr(cfg(0, 6, 17'h10000 | 17'h780)); frame();
    @(posedge clk); #2;
    chk("R5 inverted hs/vs/en", {29'b0, out_hs, out_vs, out_en}, 32'h7);
    chk("R5 pclk inverted", {31'b0, out_pclk}, 32'h0);

    // R6 falling-edge launch of hs, vsync stays rising
    wr(cfg(0, 6, 17'h10000 | 17'h040)); frame();
    @(negedge clk); pix_hs = 1'b1; pix_vs = 1'b1;
    @(posedge clk); #2;
    chk("R6 hs waits half cycle", {31'b0, out_hs}, 32'h0);
    chk("R6 vs rising launch", {31'b0, out_vs}, 32'h1);
    @(negedge clk); #2;
    chk("R6 hs after falling edge", {31'b0, out_hs}, 32'h1);
    pix_vs = 1'b0;

    // R7 disables override inversion
    wr(cfg(0, 6, 17'h10000 | 17'h208 | 17'h002)); frame();
    @(negedge clk); pix_hs = 1'b1; pix_de = 1'b1;
    @(posedge clk); #2;
    chk("R7 hs/en forced low", {30'b0, out_hs, out_en}, 32'h0);
    @(negedge clk); pix_hs = 1'b0;
    @(posedge clk); #2;
    chk("R7 inverted hs still low", {31'b0, out_hs}, 32'h0);

    // R9 composite sync on enable pin
    wr(cfg(0, 6, 17'h0)); frame();
    @(negedge clk); pix_hs = 1'b1; pix_de = 1'b0;
    @(posedge clk); #2;
    chk("R9 csync from hs", {31'b0, out_en}, 32'h1);
    @(negedge clk); pix_hs = 1'b0; pix_de = 1'b1;
    @(posedge clk); #2;
    chk("R9 de ignored in csync mode", {31'b0, out_en}, 32'h0);
    wr(cfg(0, 6, 17'h080)); frame();
    @(negedge clk); pix_hs = 1'b0; pix_de = 1'b0;
    @(posedge clk); #2;
    chk("R9 csync inverted idle", {31'b0, out_en}, 32'h1);

    // R10 deferred update
    wr(cfg(0, 6, 17'h10000)); frame();
    wr(cfg(0, 1, 17'h10000));
    @(negedge clk); pix_rgb = PX; #1;
    chk("R10 readback immediate", cfg_rdata, cfg(0, 1, 17'h10000));
    @(posedge clk); #2;
    chk("R10 old format held", {8'b0, out_data}, 32'hF18C35);
    frame();
    @(posedge clk); #2;
    chk("R10 new format after vsync", {8'b0, out_data}, 32'h00F466);

    // R8 disable and re-enable from cleared pipeline
    wr(32'h0); frame();
    @(negedge clk); pix_de = 1'b1; pix_hs = 1'b1;
    @(posedge clk); #2;
    chk("R8 disabled outputs", {5'b0, out_data, out_hs, out_vs, out_en}, 32'h0);
    chk("R8 disabled pclk", {31'b0, out_pclk}, 32'h0);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = cfg(0, 6, 17'h10000);
    @(posedge clk); #2; cfg_wr = 1'b0;
    @(posedge clk); #2;
    chk("R8 first cycle after enable cleared", {7'b0, out_data, out_hs}, 32'h0);
    @(posedge clk); #2;
    chk("R8 pixel after enable", {8'b0, out_data}, 32'hF18C35);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule